// File: doc/BRIEF.md
# Timed Interrupt-Disable Counter

This block holds back ordinary interrupt requests for a programmable number of instruction cycles. A load command arms a countdown. While the count is above zero, requests at priorities 1 to 6 are held back. Requests at the highest priority and all trap indications are never held back. Each instruction-cycle strobe lowers the count by one until it reaches zero, and then ordinary requests flow again.

Software can read the live count. It can also overwrite the count, which ends the window early when the value is zero, or add to it to stretch the window. An add saturates at the largest value the counter can hold. The block sits in front of the interrupt arbiter and does no arbitration or vectoring of its own.

Control is a two-state machine. `ST_OPEN` means the count is zero and ordinary requests pass. `ST_MASKED` means the count is nonzero and priorities 1 to 6 are blocked. The transitions are:
- **arm** (`ST_OPEN` to `ST_MASKED`): a load, write or add leaves a nonzero count.
- **expire** (`ST_MASKED` to `ST_OPEN`): the last strobe takes the count to zero.
- **cancel** (`ST_MASKED` to `ST_OPEN`): a software write of zero.
- **stay**: every other case keeps the current state.

Top module: `irq_hold_timer`

## Requirements
- R1: The counter width is the parameter CNT_W (default 14), so the maximum count is 2^CNT_W-1. Reset clears the count to 0 and the state to ST_OPEN.
- R2: A load (`ld_en`=1) sets the count to `ld_cnt`. No decrement happens in that cycle, even if `cyc_stb` is high.
- R3: While `cnt_rd` is nonzero, a request with priority 1 to 6 gives `out_req`=0.
- R4: A request with priority 7 (all ones) is always forwarded. When `out_req`=1, `out_prio` equals `irq_prio`; otherwise `out_prio` is 0.
- R5: `out_trap` equals `trap_req` in the same cycle, whatever the count.
- R6: With no load, write or add, a cycle with `cyc_stb`=1 and a nonzero count lowers the count by exactly one. A cycle without the strobe holds the count. A zero count stays at zero.
- R7: In the cycle after the count reaches zero, requests at priority 1 to 6 are forwarded again.
- R8: A software write (`sw_wr`=1) sets the count to `sw_data`. Writing 0 ends masking at once. `cnt_rd` always shows the current count.
- R9: A software add (`sw_add`=1) raises the count by `sw_data`. If the sum would exceed 2^CNT_W-1, the count saturates there.
- R10: When several commands arrive in one cycle, they take effect in this order: write, then add, then load, then decrement. Only the winner is applied.
- R11: A request with priority 0 is never forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Load command that arms the countdown |
| ld_cnt | input | CNT_W | Count used by a load |
| sw_wr | input | 1 | Software write of the counter |
| sw_add | input | 1 | Software add to the counter |
| sw_data | input | CNT_W | Value used by a write or an add |
| cyc_stb | input | 1 | One pulse per instruction cycle, stalls included |
| irq_req | input | 1 | Incoming interrupt request |
| irq_prio | input | PRIO_W | Priority of the incoming request |
| trap_req | input | 1 | Incoming trap indication |
| out_req | output | 1 | Filtered interrupt request |
| out_prio | output | PRIO_W | Priority of the forwarded request, 0 when none |
| out_trap | output | 1 | Forwarded trap indication |
| cnt_rd | output | CNT_W | Current count, for read-back |

## Verification
The bench builds the block with CNT_W=6 and PRIO_W=3. With this width, a single add reaches the saturation ceiling of 63, and a full countdown from load to expiry takes only a few strobes. Expiry, cancel, saturation and command precedence are therefore each checked at exact cycles. Keeping the priority width at 3 places the unmaskable level at 7, as in the default build.

// File: rtl/irq_hold_pkg.sv
package irq_hold_pkg;

    typedef enum logic {
        ST_OPEN   = 1'b0,
        ST_MASKED = 1'b1
    } hold_state_t;

    typedef enum logic [2:0] {
        OP_HOLD,
        OP_WRITE,
        OP_ADD,
        OP_LOAD,
        OP_DEC
    } cnt_op_t;

endpackage

// File: rtl/irq_hold_next.sv
module irq_hold_next
    import irq_hold_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic [CNT_W-1:0] cnt_q,
    input  logic             sw_wr,
    input  logic             sw_add,
    input  logic             ld_en,
    input  logic             cyc_stb,
    input  logic [CNT_W-1:0] sw_data,
    input  logic [CNT_W-1:0] ld_cnt,
    output cnt_op_t          op,
    output logic [CNT_W-1:0] cnt_d
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W:0] sum;

    assign sum = {1'b0, cnt_q} + {1'b0, sw_data};

    // Fixed precedence: write, add, load, then decrement.
    always_comb begin
        if (sw_wr)
            op = OP_WRITE;
        else if (sw_add)
            op = OP_ADD;
        else if (ld_en)
            op = OP_LOAD;
        else if (cyc_stb && (cnt_q != '0))
            op = OP_DEC;
        else
            op = OP_HOLD;
    end

    always_comb begin
        unique case (op)
            OP_WRITE: cnt_d = sw_data;
            OP_ADD:   cnt_d = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
            OP_LOAD:  cnt_d = ld_cnt;
            OP_DEC:   cnt_d = cnt_q - 1'b1;
            default:  cnt_d = cnt_q;
        endcase
    end

endmodule

// File: rtl/irq_hold_gate.sv
module irq_hold_gate #(
    parameter int PRIO_W = 3
) (
    input  logic              mask_lo,
    input  logic              irq_req,
    input  logic [PRIO_W-1:0] irq_prio,
    input  logic              trap_req,
    output logic              out_req,
    output logic [PRIO_W-1:0] out_prio,
    output logic              out_trap
);

    localparam logic [PRIO_W-1:0] PRIO_TOP = '1;

    logic is_top;
    logic is_zero;
    logic pass;

    assign is_top  = (irq_prio == PRIO_TOP);
    assign is_zero = (irq_prio == '0);
    assign pass    = irq_req && !is_zero && (is_top || !mask_lo);

    assign out_req  = pass;
    assign out_prio = pass ? irq_prio : '0;
    assign out_trap = trap_req;

endmodule

// File: rtl/irq_hold_timer.sv
module irq_hold_timer
    import irq_hold_pkg::*;
#(
    parameter int CNT_W  = 14,
    parameter int PRIO_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [CNT_W-1:0]  ld_cnt,
    input  logic              sw_wr,
    input  logic              sw_add,
    input  logic [CNT_W-1:0]  sw_data,
    input  logic              cyc_stb,
    input  logic              irq_req,
    input  logic [PRIO_W-1:0] irq_prio,
    input  logic              trap_req,
    output logic              out_req,
    output logic [PRIO_W-1:0] out_prio,
    output logic              out_trap,
    output logic [CNT_W-1:0]  cnt_rd
);

    hold_state_t      state_q, state_d;
    cnt_op_t          op;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             mask_lo;

    irq_hold_next #(.CNT_W(CNT_W)) u_next (
        .cnt_q   (cnt_q),
        .sw_wr   (sw_wr),
        .sw_add  (sw_add),
        .ld_en   (ld_en),
        .cyc_stb (cyc_stb),
        .sw_data (sw_data),
        .ld_cnt  (ld_cnt),
        .op      (op),
        .cnt_d   (cnt_d)
    );

    // Transitions: arm, expire, cancel, stay.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN:   if (cnt_d != '0) state_d = ST_MASKED;
            ST_MASKED: if (cnt_d == '0) state_d = ST_OPEN;
            default:   state_d = ST_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OPEN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_OPEN:   mask_lo = 1'b0;
            ST_MASKED: mask_lo = 1'b1;
            default:   mask_lo = 1'b0;
        endcase
    end

    irq_hold_gate #(.PRIO_W(PRIO_W)) u_gate (
        .mask_lo  (mask_lo),
        .irq_req  (irq_req),
        .irq_prio (irq_prio),
        .trap_req (trap_req),
        .out_req  (out_req),
        .out_prio (out_prio),
        .out_trap (out_trap)
    );

    assign cnt_rd = cnt_q;

endmodule

// File: rtl/irq_hold_chk.sv
module irq_hold_chk #(
    parameter int CNT_W  = 14,
    parameter int PRIO_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_en,
    input logic [CNT_W-1:0]  ld_cnt,
    input logic              sw_wr,
    input logic              sw_add,
    input logic [CNT_W-1:0]  sw_data,
    input logic              cyc_stb,
    input logic              irq_req,
    input logic [PRIO_W-1:0] irq_prio,
    input logic              trap_req,
    input logic              out_req,
    input logic [PRIO_W-1:0] out_prio,
    input logic              out_trap,
    input logic [CNT_W-1:0]  cnt_rd
);

    localparam logic [PRIO_W-1:0] PRIO_TOP = '1;
    localparam logic [CNT_W:0]    CNT_MAX  = {1'b0, {CNT_W{1'b1}}};

    // R3
    masked_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_rd != '0 && irq_req && irq_prio != '0 && irq_prio != PRIO_TOP) |-> !out_req);

    // R4
    top_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_prio == PRIO_TOP) |-> (out_req && out_prio == PRIO_TOP));

    // R5
    trap_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_trap == trap_req);

    // R11
    zero_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_prio == '0) |-> !out_req);

    // R6
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_stb && cnt_rd != '0 && !sw_wr && !sw_add && !ld_en)
        |=> cnt_rd == $past(cnt_rd) - 1'b1);

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_stb && !sw_wr && !sw_add && !ld_en) |=> $stable(cnt_rd));

    // R8
    write_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr |=> cnt_rd == $past(sw_data));

    // R9
    add_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_add && !sw_wr && ({1'b0, cnt_rd} + {1'b0, sw_data}) > CNT_MAX)
        |=> cnt_rd == '1);

    // R2
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && !sw_wr && !sw_add) |=> cnt_rd == $past(ld_cnt));

endmodule

bind irq_hold_timer irq_hold_chk #(.CNT_W(CNT_W), .PRIO_W(PRIO_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_en    (ld_en),
    .ld_cnt   (ld_cnt),
    .sw_wr    (sw_wr),
    .sw_add   (sw_add),
    .sw_data  (sw_data),
    .cyc_stb  (cyc_stb),
    .irq_req  (irq_req),
    .irq_prio (irq_prio),
    .trap_req (trap_req),
    .out_req  (out_req),
    .out_prio (out_prio),
    .out_trap (out_trap),
    .cnt_rd   (cnt_rd)
);

// File: tb/irq_hold_timer_bench.sv
module irq_hold_timer_bench;

    localparam int CNT_W  = 6;
    localparam int PRIO_W = 3;
    localparam int NVEC   = 13;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ld_en = 1'b0;
    logic [CNT_W-1:0]  ld_cnt = '0;
    logic              sw_wr = 1'b0;
    logic              sw_add = 1'b0;
    logic [CNT_W-1:0]  sw_data = '0;
    logic              cyc_stb = 1'b0;
    logic              irq_req = 1'b0;
    logic [PRIO_W-1:0] irq_prio = '0;
    logic              trap_req = 1'b0;
    logic              out_req;
    logic [PRIO_W-1:0] out_prio;
    logic              out_trap;
    logic [CNT_W-1:0]  cnt_rd;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_hold_timer #(.CNT_W(CNT_W), .PRIO_W(PRIO_W)) u_irq_hold_timer (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_cnt(ld_cnt),
        .sw_wr(sw_wr), .sw_add(sw_add), .sw_data(sw_data), .cyc_stb(cyc_stb),
        .irq_req(irq_req), .irq_prio(irq_prio), .trap_req(trap_req),
        .out_req(out_req), .out_prio(out_prio), .out_trap(out_trap), .cnt_rd(cnt_rd)
    );

    // Row fields: wr, add, ld, stb, data[6], irq, prio[3], trap, exp_req, exp_cnt[6]
    localparam logic [21:0] VEC [NVEC] = '{
        {4'b0000, 6'd0,  1'b1, 3'd3, 1'b0, 1'b1, 6'd0 },  // R7 open, prio 3 passes
        {4'b0010, 6'd3,  1'b1, 3'd3, 1'b0, 1'b1, 6'd3 },  // R2 load
        {4'b0001, 6'd0,  1'b1, 3'd3, 1'b0, 1'b0, 6'd2 },  // R3 R6
        {4'b0001, 6'd0,  1'b1, 3'd7, 1'b0, 1'b1, 6'd1 },  // R4 R6
        {4'b0000, 6'd0,  1'b1, 3'd1, 1'b0, 1'b0, 6'd1 },  // R3 R6 hold
        {4'b0001, 6'd0,  1'b0, 3'd0, 1'b1, 1'b0, 6'd0 },  // R6 expiry
        {4'b0001, 6'd0,  1'b1, 3'd6, 1'b0, 1'b1, 6'd0 },  // R7 R6 stays 0
        {4'b0000, 6'd0,  1'b1, 3'd0, 1'b0, 1'b0, 6'd0 },  // R11
        {4'b1001, 6'd10, 1'b1, 3'd2, 1'b0, 1'b1, 6'd10},  // R8 R10 write over dec
        {4'b0101, 6'd5,  1'b1, 3'd2, 1'b0, 1'b0, 6'd15},  // R9 R10 add over dec
        {4'b0101, 6'd60, 1'b0, 3'd0, 1'b0, 1'b0, 6'd63},  // R9 saturate
        {4'b1001, 6'd0,  1'b1, 3'd5, 1'b0, 1'b0, 6'd0 },  // R8 cancel
        {4'b0000, 6'd0,  1'b1, 3'd5, 1'b0, 1'b1, 6'd0 }   // R8 R7 unmasked
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        ld_en = 0; sw_wr = 0; sw_add = 0; cyc_stb = 0;
        irq_req = 0; irq_prio = '0; trap_req = 0; ld_cnt = '0; sw_data = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        irq_req = 1; irq_prio = 3'd4;
        #1;
        chk(cnt_rd == 0, "R1 reset count", cnt_rd, 0);
        chk(out_req == 1, "R1 reset open", out_req, 1);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            sw_wr    = VEC[i][21];
            sw_add   = VEC[i][20];
            ld_en    = VEC[i][19];
            cyc_stb  = VEC[i][18];
            sw_data  = VEC[i][17:12];
            ld_cnt   = VEC[i][17:12];
            irq_req  = VEC[i][11];
            irq_prio = VEC[i][10:8];
            trap_req = VEC[i][7];
            #1;
            chk(out_req == VEC[i][6], $sformatf("R3/R4/R7/R11 row %0d out_req", i),
                out_req, VEC[i][6]);
            chk(out_prio == (VEC[i][6] ? VEC[i][10:8] : 3'd0),
                $sformatf("R4 row %0d out_prio", i), out_prio,
                VEC[i][6] ? VEC[i][10:8] : 0);
            chk(out_trap == VEC[i][7], $sformatf("R5 row %0d out_trap", i),
                out_trap, VEC[i][7]);
            @(posedge clk); #1;
            chk(cnt_rd == VEC[i][5:0], $sformatf("R6/R8/R9/R10 row %0d count", i),
                cnt_rd, VEC[i][5:0]);
        end

        // R10 write beats load
        @(negedge clk); idle_inputs();
        sw_wr = 1; sw_data = 6'd9; ld_en = 1; ld_cnt = 6'd20;
        @(posedge clk); #1;
        chk(cnt_rd == 9, "R10 write over load", cnt_rd, 9);

        // R10 add beats load
        @(negedge clk); idle_inputs();
        sw_add = 1; sw_data = 6'd2; ld_en = 1; ld_cnt = 6'd30;
        @(posedge clk); #1;
        chk(cnt_rd == 11, "R10 add over load", cnt_rd, 11);

        // R2 load with strobe: no decrement
        @(negedge clk); idle_inputs();
        ld_en = 1; ld_cnt = 6'd5; cyc_stb = 1;
        @(posedge clk); #1;
        chk(cnt_rd == 5, "R2 load with strobe", cnt_rd, 5);

        // R5 trap while masked
        @(negedge clk); idle_inputs();
        trap_req = 1; irq_req = 1; irq_prio = 3'd7;
        #1;
        chk(out_trap == 1, "R5 trap masked", out_trap, 1);
        chk(out_prio == 7, "R4 prio 7 masked", out_prio, 7);

        // R6 R7 countdown to expiry
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); idle_inputs();
            cyc_stb = 1; irq_req = 1; irq_prio = 3'd4;
            #1;
            chk(out_req == 0, "R3 countdown blocked", out_req, 0);
            @(posedge clk); #1;
            chk(cnt_rd == 4 - k, "R6 countdown step", cnt_rd, 4 - k);
        end
        @(negedge clk); idle_inputs();
        irq_req = 1; irq_prio = 3'd4;
        #1;
        chk(out_req == 1, "R7 reopened after expiry", out_req, 1);

        // R1 max count and reset mid-run
        @(negedge clk); idle_inputs();
        sw_wr = 1; sw_data = '1;
        @(posedge clk); #1;
        chk(cnt_rd == 63, "R1 max count", cnt_rd, 63);
        @(negedge clk); idle_inputs(); rst_n = 0;
        @(posedge clk); #1;
        chk(cnt_rd == 0, "R1 reset clears", cnt_rd, 0);
        @(negedge clk); rst_n = 1;

        finish_run();
    end

endmodule